// File: doc/BRIEF.md
# Video Digitiser Clamp and Output Control

This block is the digital side of an 8-bit video digitiser. In every clock cycle it takes the raw conversion code and its out-of-range flags and saturates the code. It then compares the code with a black-level target. The target is code 16 for red, green and blue signals and code 128 for chroma and colour-difference signals. While the clamp pulse is high, the block tells an external clamp current source to source current, sink current or stay idle. The analog loop then pulls the black level of the signal toward the target.

The same saturated code goes down a short pipeline that models the conversion latency. In the last stage it is formatted as offset binary or as two's complement. It reaches the data bus only while the active-low output enable is low, and an external pad driver uses the drive-enable output. A small decoder turns the two-bit source select into a one-hot select for three video inputs.

Top module: `vid_clamp_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first falling edge after it is released, `clamp_cmd_o` is 2'b00 and `data_o` is 8'h00.
- R2: When `clamp_en_i` was low at a rising edge, `clamp_cmd_o` is 2'b00 after that edge, whatever `lvl_hi_i` and the code are.
- R3: The clamp target is code 16 when `lvl_hi_i` is 0 and code 128 when `lvl_hi_i` is 1. If `clamp_en_i` is high and the saturated code is below the target at a rising edge, `clamp_cmd_o` is 2'b01 (source) after that edge.
- R4: If `clamp_en_i` is high and the saturated code is above the target at a rising edge, `clamp_cmd_o` is 2'b10 (sink) after that edge.
- R5: If `clamp_en_i` is high and the saturated code equals the target, `clamp_cmd_o` is 2'b00. The value 2'b11 never appears on `clamp_cmd_o`.
- R6: `vin_sel_o` is one-hot and combinational. `src_sel_i` 2'b00 gives 3'b001, 2'b01 gives 3'b010, 2'b10 gives 3'b100, and 2'b11 also gives 3'b010.
- R7: A code presented before rising edge k appears on `data_o` after rising edge k+2. This is three edges of latency.
- R8: When `fmt_tc_i` is 0 the output is the code in offset binary. When it is 1 the output is the code with bit 7 inverted (0 gives 8'h80, 255 gives 8'h7F).
- R9: When `over_i` is 1 the code is taken as 255. When only `under_i` is 1 it is taken as 0. Overflow wins if both are set. Saturation applies to both the clamp comparison and the data path.
- R10: `fmt_tc_i` is sampled only at the edge that loads the output stage. A change in format applies to every word leaving the pipe from that edge on.
- R11: While `oe_n_i` is 1, `data_oe_o` is 0 and `data_o` is 8'h00. While `oe_n_i` is 0, `data_oe_o` is 1 and `data_o` carries the formatted word. Both follow `oe_n_i` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 8 | Raw conversion code |
| under_i | input | 1 | Input below range |
| over_i | input | 1 | Input above range |
| lvl_hi_i | input | 1 | Target select: 0 selects code 16, 1 selects code 128 |
| clamp_en_i | input | 1 | Clamp pulse |
| src_sel_i | input | 2 | Video source select code |
| fmt_tc_i | input | 1 | 1 selects two's complement output |
| oe_n_i | input | 1 | Active-low output enable |
| vin_sel_o | output | 3 | One-hot video input select |
| clamp_cmd_o | output | 2 | Clamp current command: 00 idle, 01 source, 10 sink |
| data_o | output | 8 | Formatted output word |
| data_oe_o | output | 1 | Pad drive enable for `data_o` |

## Verification
The clamp command is due one rising edge after the inputs it depends on. The data word is due three rising edges after its code is applied, and it takes the format present at the third edge. The source select and the enable outputs are due in the same cycle, with no clock. The bench changes inputs on falling edges and checks the combinational outputs shortly after it drives them. The reference model steps at each rising edge, and the registered outputs are compared with it at the next falling edge, so every expected value lines up with the edge that produced it.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
    typedef enum logic [1:0] {
        CLAMP_OFF = 2'b00,
        CLAMP_SRC = 2'b01,
        CLAMP_SNK = 2'b10
    } clamp_cmd_e;
endpackage

// File: rtl/vcc_src_decode.sv
module vcc_src_decode (
    input  logic [1:0] src_sel_i,
    output logic [2:0] vin_sel_o
);
    // Code 2'b11 aliases onto input 1.
    always_comb begin
        unique case (src_sel_i)
            2'b00:   vin_sel_o = 3'b001;
            2'b01:   vin_sel_o = 3'b010;
            2'b10:   vin_sel_o = 3'b100;
            default: vin_sel_o = 3'b010;
        endcase
    end
endmodule

// File: rtl/vcc_clamp_cmp.sv
module vcc_clamp_cmp
    import vcc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TGT_LO = 16,
    parameter int TGT_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] code_i,
    input  logic              lvl_hi_i,
    input  logic              clamp_en_i,
    output clamp_cmd_e        cmd_o
);
    localparam logic [DATA_W-1:0] TLO = DATA_W'(TGT_LO);
    localparam logic [DATA_W-1:0] THI = DATA_W'(TGT_HI);

    typedef struct packed {
        clamp_cmd_e cmd;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic [DATA_W-1:0] target;

    always_comb begin
        target = lvl_hi_i ? THI : TLO;
        st_d   = st_q;
        if (!clamp_en_i)
            st_d.cmd = CLAMP_OFF;
        else if (code_i < target)
            st_d.cmd = CLAMP_SRC;
        else if (code_i > target)
            st_d.cmd = CLAMP_SNK;
        else
            st_d.cmd = CLAMP_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{cmd: CLAMP_OFF};
        else
            st_q <= st_d;
    end

    assign cmd_o = st_q.cmd;
endmodule

// File: rtl/vcc_out_pipe.sv
module vcc_out_pipe #(
    parameter int DATA_W = 8,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] code_i,
    input  logic              fmt_tc_i,
    output logic [DATA_W-1:0] word_o
);
    // LAT-1 plain stages, then the formatting output stage (LAT >= 2).
    localparam int NSTG = LAT - 1;
    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [NSTG-1:0][DATA_W-1:0] stg;
        logic [DATA_W-1:0]           out;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = code_i;
        for (int i = 1; i < NSTG; i++)
            st_d.stg[i] = st_q.stg[i-1];
        st_d.out = fmt_tc_i ? (st_q.stg[NSTG-1] ^ MSB_MASK) : st_q.stg[NSTG-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign word_o = st_q.out;
endmodule

// File: rtl/vid_clamp_ctrl.sv
module vid_clamp_ctrl
    import vcc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LAT    = 3,
    parameter int TGT_LO = 16,
    parameter int TGT_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              under_i,
    input  logic              over_i,
    input  logic              lvl_hi_i,
    input  logic              clamp_en_i,
    input  logic [1:0]        src_sel_i,
    input  logic              fmt_tc_i,
    input  logic              oe_n_i,
    output logic [2:0]        vin_sel_o,
    output logic [1:0]        clamp_cmd_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    logic [DATA_W-1:0] code_sat;
    logic [DATA_W-1:0] word;
    clamp_cmd_e        cmd;

    // Overflow takes priority over underflow.
    always_comb begin
        if (over_i)       code_sat = '1;
        else if (under_i) code_sat = '0;
        else              code_sat = sample_i;
    end

    vcc_src_decode i_dec (
        .src_sel_i (src_sel_i),
        .vin_sel_o (vin_sel_o)
    );

    vcc_clamp_cmp #(
        .DATA_W (DATA_W),
        .TGT_LO (TGT_LO),
        .TGT_HI (TGT_HI)
    ) i_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (code_sat),
        .lvl_hi_i   (lvl_hi_i),
        .clamp_en_i (clamp_en_i),
        .cmd_o      (cmd)
    );

    vcc_out_pipe #(
        .DATA_W (DATA_W),
        .LAT    (LAT)
    ) i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_i   (code_sat),
        .fmt_tc_i (fmt_tc_i),
        .word_o   (word)
    );

    assign clamp_cmd_o = cmd;
    assign data_oe_o   = ~oe_n_i;
    assign data_o      = oe_n_i ? '0 : word;
endmodule

// File: rtl/vcc_chk.sv
module vcc_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              under_i,
    input logic              over_i,
    input logic              lvl_hi_i,
    input logic              clamp_en_i,
    input logic [1:0]        src_sel_i,
    input logic              oe_n_i,
    input logic [2:0]        vin_sel_o,
    input logic [1:0]        clamp_cmd_o,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe_o
);
    // R2
    clamp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_en_i |=> clamp_cmd_o == 2'b00);

    // R5
    no_bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_cmd_o != 2'b11);

    // R4 R9
    over_sinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en_i && over_i) |=> clamp_cmd_o == 2'b10);

    // R3 R9
    under_sources_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en_i && under_i && !over_i) |=> clamp_cmd_o == 2'b01);

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vin_sel_o) == 1);

    // R6
    sel_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_i == 2'b11 |-> vin_sel_o == 3'b010);

    // R11
    bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!data_oe_o && data_o == '0));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (clamp_cmd_o == 2'b00 && data_o == '0));

    logic unused_lvl;
    assign unused_lvl = lvl_hi_i;
endmodule

bind vid_clamp_ctrl vcc_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_vid_clamp_ctrl.sv
module test_vid_clamp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sample_i = '0;
    logic       under_i = 1'b0, over_i = 1'b0, lvl_hi_i = 1'b0, clamp_en_i = 1'b0;
    logic [1:0] src_sel_i = '0;
    logic       fmt_tc_i = 1'b0, oe_n_i = 1'b0;
    logic [2:0] vin_sel_o;
    logic [1:0] clamp_cmd_o;
    logic [7:0] data_o;
    logic       data_oe_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int q[$];
    int exp_word = 0;
    int exp_cmd = 0;

    always #2 clk = ~clk;

    vid_clamp_ctrl i_vid_clamp_ctrl (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_code();
        if (over_i) return 255;
        if (under_i) return 0;
        return int'(sample_i);
    endfunction

    // One clock: check combinational outputs, model the edge, compare registers.
    task automatic step();
        int code, tgt, w, vexp;
        #1;
        case (src_sel_i)
            2'd0: vexp = 1;
            2'd2: vexp = 4;
            default: vexp = 2;
        endcase
        chk("R6 vin_sel", int'(vin_sel_o), vexp);
        @(posedge clk);
        code = sat_code();
        tgt = lvl_hi_i ? 128 : 16;
        if (!clamp_en_i) exp_cmd = 0;
        else if (code < tgt) exp_cmd = 1;
        else if (code > tgt) exp_cmd = 2;
        else exp_cmd = 0;
        w = q.pop_front();
        exp_word = fmt_tc_i ? (w + 128) % 256 : w;
        q.push_back(code);
        @(negedge clk);
        chk("R2-5 clamp_cmd", int'(clamp_cmd_o), exp_cmd);
        if (oe_n_i) begin
            chk("R11 data hiZ", int'(data_o), 0);
            chk("R11 oe off", int'(data_oe_o), 0);
        end else begin
            chk("R7 R8 R10 data", int'(data_o), exp_word);
            chk("R11 oe on", int'(data_oe_o), 1);
        end
    endtask

    task automatic drive(int s, bit en, bit hi);
        sample_i = 8'(s); clamp_en_i = en; lvl_hi_i = hi;
        step();
    endtask

    initial begin
        q = {0, 0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1 cmd reset", int'(clamp_cmd_o), 0);
        chk("R1 data reset", int'(data_o), 0);
        rst_n = 1'b1;
        chk("R1 cmd after release", int'(clamp_cmd_o), 0);
        // R3 R4 R5 with target 16
        drive(5, 1, 0); drive(16, 1, 0); drive(17, 1, 0); drive(200, 1, 0);
        // R3 R4 R5 with target 128
        drive(127, 1, 1); drive(128, 1, 1); drive(129, 1, 1); drive(16, 1, 1);
        // R2 pulse low
        drive(0, 0, 0); drive(255, 0, 1); drive(16, 0, 0);
        // R7 latency marker sequence
        drive(11, 0, 0); drive(22, 0, 0); drive(33, 0, 0); drive(44, 0, 0);
        // R8 R10 format switch mid-stream
        fmt_tc_i = 1'b1; drive(0, 0, 0); drive(255, 0, 0); drive(1, 0, 0);
        fmt_tc_i = 1'b0; drive(2, 0, 0); drive(3, 0, 0);
        fmt_tc_i = 1'b1; drive(4, 0, 0); drive(5, 0, 0); drive(6, 0, 0);
        fmt_tc_i = 1'b0;
        // R9 saturation, overflow priority
        over_i = 1'b1; drive(3, 1, 1);
        under_i = 1'b1; drive(200, 1, 0);
        over_i = 1'b0; drive(200, 1, 1); drive(200, 1, 0);
        under_i = 1'b0;
        // R6 all select codes
        for (int i = 0; i < 4; i++) begin
            src_sel_i = 2'(i);
            drive(i * 50, 0, 0);
        end
        // R11 enable toggling
        oe_n_i = 1'b1; drive(77, 0, 0); drive(88, 0, 0);
        oe_n_i = 1'b0; drive(99, 0, 0); drive(0, 0, 0);
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            src_sel_i = 2'($urandom_range(0, 3));
            fmt_tc_i = 1'($urandom_range(0, 1));
            oe_n_i = ($urandom_range(0, 7) == 0);
            under_i = ($urandom_range(0, 15) == 0);
            over_i = ($urandom_range(0, 15) == 0);
            drive($urandom_range(0, 255), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule